// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Memory

This block is a small synchronous two-port memory in which each port can also signal the other. The two highest words of the array act as mailboxes. When port B writes the word at the second-highest address, port A's interrupt goes active. When port A writes the highest address, port B's interrupt goes active. Each receiving port acknowledges by accessing its own incoming mailbox with chip select and output enable both active. The mailbox words stay ordinary user data in the shared array, so a sender typically leaves a message in the word, and the receiver reads it and clears the interrupt in the same access.

Both ports have active-low chip select, write enable and output enable, an address and write data. Each port has a registered read-data output and an active-low interrupt output. A parameter turns the mailbox function off. The top two words are then plain storage and the interrupts never assert. The address width is a parameter, and the mailbox addresses always sit at the top of the array.

Top module: `mailbox_dpram`

## Requirements
- R1: During and after reset, both interrupt outputs are high (inactive) and both read-data outputs are zero.
- R2: A write (chip select low, write enable low) stores data at the clock edge. A read (chip select low, output enable low, write enable high) presents the word on that port's read data after the edge that samples it. A read and a write to the same word in the same cycle return the previous contents.
- R3: Either port can write and read every address of the array. A word written by one port is read back unchanged by the other.
- R4: A write by port B to address 2^ADDR_W-2 drives `a_irq_n` low after that clock edge.
- R5: Port A clears `a_irq_n` (drives it high) by an access to address 2^ADDR_W-2 with chip select and output enable both low, whatever the level of its write enable.
- R6: A write by port A to address 2^ADDR_W-1 drives `b_irq_n` low. Port B clears it by an access to that address with chip select and output enable both low.
- R7: If a set and a clear reach the same interrupt in the same cycle, the interrupt ends up active.
- R8: Mailbox words hold the user data written to them and read back like any other word.
- R9: An interrupt is left unchanged by these accesses: reads or writes to other addresses, a port writing its own incoming mailbox, and accesses to the incoming mailbox with output enable high or chip select high.
- R10: With MBX_EN = 0, both interrupt outputs stay high, and the top two words behave as plain memory.
- R11: When both ports write the same address in the same cycle, port A's data is stored.
- R12: With chip select high, a port neither writes nor reads. When a port is not reading, its read-data output holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_we_n | input | 1 | Port A write enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_we_n | input | 1 | Port B write enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
Every result in this block is due one clock edge after its stimulus. Stored data becomes readable in the next cycle. Read data appears after the edge that samples the read. An interrupt flag rises or falls at the edge that sees the mailbox write or the acknowledging access. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. A second instance with the mailboxes disabled shares the same stimulus, and its interrupts are checked at each phase.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Incoming mailbox of a port: port 0 (A) owns top-1, port 1 (B) owns top.
  function automatic int unsigned mbx_inbox(input int unsigned aw, input int unsigned port);
    return (1 << aw) - 2 + port;
  endfunction

  function automatic logic port_writes(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

  function automatic logic port_reads(input logic cs_n, input logic oe_n, input logic we_n);
    return !cs_n && !oe_n && we_n;
  endfunction

  // Acknowledge condition: selected with output enabled, write enable ignored.
  function automatic logic port_acks(input logic cs_n, input logic oe_n);
    return !cs_n && !oe_n;
  endfunction

endpackage

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);
  logic flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

  assign irq_n = ~flag;

  // set wins over a concurrent clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> !irq_n);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> irq_n);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_dp_array.sv
module mbx_dp_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   wr_en,
  input  logic [1:0]                   rd_en,
  input  logic [1:0][ADDR_W-1:0]       addr,
  input  logic [1:0][DATA_W-1:0]       wdata,
  output logic [1:0][DATA_W-1:0]       rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port 1 first, port 0 last: port 0 (A) wins a same-address collision.
  always_ff @(posedge clk) begin
    for (int p = 1; p >= 0; p--) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_en[p]) rdata[p] <= mem[addr[p]];
    end

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[p] |=> $stable(rdata[p]));
  end

endmodule

// File: rtl/mailbox_dpram.sv
module mailbox_dpram
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter bit MBX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq_n,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq_n
);
  logic [1:0]                 cs_n, we_n, oe_n;
  logic [1:0][ADDR_W-1:0]     addr;
  logic [1:0][DATA_W-1:0]     wdata, rdata;
  logic [1:0]                 wr_evt, rd_evt, ack_evt;
  logic [1:0]                 set_evt, clr_evt, irq_n;

  assign cs_n  = {b_cs_n, a_cs_n};
  assign we_n  = {b_we_n, a_we_n};
  assign oe_n  = {b_oe_n, a_oe_n};
  assign addr  = {b_addr, a_addr};
  assign wdata = {b_wdata, a_wdata};

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam logic [ADDR_W-1:0] INBOX = ADDR_W'(mbx_inbox(ADDR_W, p));

    assign wr_evt[p]  = port_writes(cs_n[p], we_n[p]);
    assign rd_evt[p]  = port_reads(cs_n[p], oe_n[p], we_n[p]);
    assign ack_evt[p] = port_acks(cs_n[p], oe_n[p]);

    // set by the opposite port writing this port's inbox
    assign set_evt[p] = MBX_EN && wr_evt[1-p] && (addr[1-p] == INBOX);
    assign clr_evt[p] = MBX_EN && ack_evt[p]  && (addr[p]   == INBOX);

    mbx_irq_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[p]),
      .clr_evt (clr_evt[p]),
      .irq_n   (irq_n[p])
    );
  end

  mbx_dp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_evt),
    .rd_en (rd_evt),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];
  assign a_irq_n = irq_n[0];
  assign b_irq_n = irq_n[1];

  // a write by A to its own inbox never raises A's interrupt
  assert_own_inbox_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_irq_n && wr_evt[0] && !wr_evt[1]) |=> a_irq_n);

endmodule

// File: tb/sim_mailbox_dpram.sv
module sim_mailbox_dpram;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_cs_n, a_we_n, a_oe_n, b_cs_n, b_we_n, b_oe_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic [DW-1:0] a_rdata, b_rdata, a_rdata1, b_rdata1;
  logic a_irq_n, b_irq_n, a_irq1_n, b_irq1_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_mem [N];

  always #2 clk = ~clk;

  mailbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .MBX_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq_n(a_irq_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq_n(b_irq_n));

  mailbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .MBX_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata1), .a_irq_n(a_irq1_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata1), .b_irq_n(b_irq1_n));

  function automatic logic [DW-1:0] pat_a(input int i);
    return 16'hA500 ^ DW'(i * 16'h0111);
  endfunction

  function automatic logic [DW-1:0] pat_b(input int i);
    return 16'h3C00 + DW'(i * 16'h0203);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drv_a(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_cs_n = cs; a_we_n = we; a_oe_n = oe; a_addr = ad; a_wdata = d;
  endtask

  task automatic drv_b(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_cs_n = cs; b_we_n = we; b_oe_n = oe; b_addr = ad; b_wdata = d;
  endtask

  task automatic idle();
    drv_a(1'b1, 1'b1, 1'b1, '0, '0);
    drv_b(1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_u1_quiet(input string tag);
    chk({tag, " u1 a_irq_n"}, 32'(a_irq1_n), 32'd1);
    chk({tag, " u1 b_irq_n"}, 32'(b_irq1_n), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 a_irq_n in reset", 32'(a_irq_n), 32'd1);
    chk("R1 b_irq_n in reset", 32'(b_irq_n), 32'd1);
    rst_n = 1'b1;
    tick();
    chk("R1 a_irq_n", 32'(a_irq_n), 32'd1);
    chk("R1 b_irq_n", 32'(b_irq_n), 32'd1);
    chk("R1 a_rdata", 32'(a_rdata), 32'd0);
    chk("R1 b_rdata", 32'(b_rdata), 32'd0);

    // A fills the whole array, including both mailboxes
    for (int i = 0; i < N; i++) begin
      drv_a(1'b0, 1'b0, 1'b1, AW'(i), pat_a(i));
      tick();
      exp_mem[i] = pat_a(i);
    end
    idle();
    chk("R6 b_irq_n set by A write to top", 32'(b_irq_n), 32'd0);
    chk("R9 A write to own inbox, a_irq_n", 32'(a_irq_n), 32'd1);
    chk_u1_quiet("R10 after A sweep");

    // B reads everything back
    for (int i = 0; i < N; i++) begin
      drv_b(1'b0, 1'b1, 1'b0, AW'(i), '0);
      tick();
      chk("R3 B reads A data", 32'(b_rdata), 32'(exp_mem[i]));
      chk("R10 u1 plain memory", 32'(b_rdata1), 32'(exp_mem[i]));
      if (i == N - 2) chk("R9 other reads keep b_irq_n", 32'(b_irq_n), 32'd0);
    end
    idle();
    chk("R8 B mailbox word", 32'(b_rdata), 32'(pat_a(N - 1)));
    chk("R6 b_irq_n cleared by B read", 32'(b_irq_n), 32'd1);

    // B fills the array, A reads back
    for (int i = 0; i < N; i++) begin
      drv_b(1'b0, 1'b0, 1'b1, AW'(i), pat_b(i));
      tick();
      exp_mem[i] = pat_b(i);
    end
    idle();
    chk("R4 a_irq_n set by B write", 32'(a_irq_n), 32'd0);
    chk("R9 B write to own inbox, b_irq_n", 32'(b_irq_n), 32'd1);
    chk_u1_quiet("R10 after B sweep");
    for (int i = 0; i < N; i++) begin
      drv_a(1'b0, 1'b1, 1'b0, AW'(i), '0);
      tick();
      chk("R3 A reads B data", 32'(a_rdata), 32'(exp_mem[i]));
      if (i == N - 3) chk("R9 other reads keep a_irq_n", 32'(a_irq_n), 32'd0);
      if (i == N - 2) chk("R5 a_irq_n cleared by read", 32'(a_irq_n), 32'd1);
    end
    idle();

    // clear with write enable low as well
    drv_b(1'b0, 1'b0, 1'b1, AW'(N - 2), 16'h1234);
    tick(); idle(); exp_mem[N - 2] = 16'h1234;
    chk("R4 a_irq_n set again", 32'(a_irq_n), 32'd0);
    drv_a(1'b0, 1'b0, 1'b0, AW'(N - 2), 16'hBEEF);
    tick(); idle(); exp_mem[N - 2] = 16'hBEEF;
    chk("R5 clear with we_n low", 32'(a_irq_n), 32'd1);
    drv_b(1'b0, 1'b1, 1'b0, AW'(N - 2), '0);
    tick(); idle();
    chk("R8 mailbox holds A write", 32'(b_rdata), 32'hBEEF);

    // accesses that must not clear
    drv_b(1'b0, 1'b0, 1'b1, AW'(N - 2), 16'h5151);
    tick(); idle(); exp_mem[N - 2] = 16'h5151;
    held = a_rdata;
    drv_a(1'b0, 1'b1, 1'b1, AW'(N - 2), '0);
    tick(); idle();
    chk("R9 oe_n high keeps a_irq_n", 32'(a_irq_n), 32'd0);
    chk("R12 no read holds a_rdata", 32'(a_rdata), 32'(held));
    drv_a(1'b1, 1'b1, 1'b0, AW'(N - 2), '0);
    tick(); idle();
    chk("R9 cs_n high keeps a_irq_n", 32'(a_irq_n), 32'd0);
    chk("R12 deselected holds a_rdata", 32'(a_rdata), 32'(held));
    drv_a(1'b0, 1'b0, 1'b1, AW'(N - 2), 16'h7777);
    tick(); idle(); exp_mem[N - 2] = 16'h7777;
    chk("R9 write without oe keeps a_irq_n", 32'(a_irq_n), 32'd0);

    // clear, then set and clear together
    drv_a(1'b0, 1'b1, 1'b0, AW'(N - 2), '0);
    tick(); idle();
    chk("R5 read clears", 32'(a_irq_n), 32'd1);
    chk("R8 A mailbox data", 32'(a_rdata), 32'h7777);
    drv_a(1'b0, 1'b1, 1'b0, AW'(N - 2), '0);
    drv_b(1'b0, 1'b0, 1'b1, AW'(N - 2), 16'h9A9A);
    tick(); idle();
    chk("R7 set wins on a_irq_n", 32'(a_irq_n), 32'd0);
    chk("R2 read-before-write", 32'(a_rdata), 32'h7777);
    exp_mem[N - 2] = 16'h9A9A;
    drv_a(1'b0, 1'b0, 1'b1, AW'(N - 1), 16'h4242);
    drv_b(1'b0, 1'b1, 1'b0, AW'(N - 1), '0);
    tick(); idle();
    chk("R7 set wins on b_irq_n", 32'(b_irq_n), 32'd0);
    chk("R2 B read-before-write", 32'(b_rdata), 32'(exp_mem[N - 1]));
    exp_mem[N - 1] = 16'h4242;
    chk_u1_quiet("R10 after collisions");

    // both ports write one address
    drv_a(1'b0, 1'b0, 1'b1, AW'(3), 16'h1111);
    drv_b(1'b0, 1'b0, 1'b1, AW'(3), 16'h2222);
    tick(); idle(); exp_mem[3] = 16'h1111;
    drv_b(1'b0, 1'b1, 1'b0, AW'(3), '0);
    tick(); idle();
    chk("R11 port A wins", 32'(b_rdata), 32'h1111);

    // deselected write ignored
    drv_a(1'b1, 1'b0, 1'b1, AW'(3), 16'hDEAD);
    tick(); idle();
    drv_b(1'b0, 1'b1, 1'b0, AW'(3), '0);
    tick(); idle();
    chk("R12 cs_n high blocks write", 32'(b_rdata), 32'h1111);
    drv_a(1'b0, 1'b1, 1'b0, AW'(N - 1), '0);
    tick(); idle();
    chk("R8 top word data", 32'(a_rdata), 32'h4242);
    chk("R10 u1 top word data", 32'(a_rdata1), 32'h4242);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule